// File: doc/BRIEF.md
# Dual Double-Buffered DAC Register Controller

This block keeps the digital register state behind a two-channel DAC. Each channel owns an input register and an output register. The output register drives the converter code. An 8-bit control register sets four things: a 2-bit power/mode field per channel, an op-amp enable, a reference-buffer setting, and a reference enable. The reference-enable bit is also reachable at a second address, the ADC control location. Both addresses share one stored bit.

The host uses a synchronous write port made of `wr_en`, `wr_addr` and `wr_data`, plus a combinational read port. Each channel's mode field controls two things: whether the channel is powered, and how a data write to that channel moves codes between its two registers. All updates take effect on the rising clock edge that samples `wr_en` high. The new values appear at the outputs after that edge.

Address map: 0 is the channel A data register, 1 is the channel B data register, 2 is the DAC control byte, and 3 is the ADC control location. Addresses 4 to 7 are unmapped.

Top module: `dual_dac_regs`

## Requirements
- R1: The control byte at address 2 holds these fields: bits [7:6] are the channel A mode, bits [5:4] are the channel B mode, bit 3 is the op-amp enable, bits [2:1] are the reference-buffer setting, and bit 0 is the reference enable. A read of address 2 returns the stored byte in `rd_data[7:0]`, with all upper bits 0.
- R2: While `rst_n` is low, every control field, input register and output register is 0. Both channels and the op amp are therefore off.
- R3: `ch_powered[i]` and `ch_oe[i]` are 1 exactly when the channel's mode is not 00. Mode 00 deasserts the output enable, so the output is treated as high impedance.
- R4: In mode 01, a data write copies the channel's current input register into its output register. The written value is ignored, and the input register is unchanged.
- R5: In mode 10, a data write loads the input register only. The output register is unchanged.
- R6: In mode 11, a data write loads the written code into both the input register and the output register at the same edge.
- R7: In mode 00, a data write still loads the input register. The output register holds its value.
- R8: The reference enable is stored once. A write to address 2 sets it from bit 0. A write to address 3 sets it from bit 0 and leaves every other control field unchanged. Address 3 reads back the same bit in bit 0, with all other bits 0.
- R9: `opamp_on` equals control bit 3 and `refbuf_sel` equals control bits [2:1]. `ref_en` equals the stored reference bit.
- R10: A write to one channel's data address changes only that channel's registers, and that channel's own mode field decides the effect. A read of a channel's data address returns its input register.
- R11: A write to an unmapped address changes no register. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (3) | Write address |
| wr_data | input | BUS_W (16) | Write data; the DAC code sits in the low DAC_W bits |
| rd_addr | input | ADDR_W (3) | Read address |
| rd_data | output | BUS_W (16) | Combinational read data |
| ch_code | output | 2*DAC_W (24) | Output-register codes; channel A in the low DAC_W bits |
| ch_powered | output | 2 | Per-channel powered-up flag; bit 0 is channel A |
| ch_oe | output | 2 | Per-channel output enable; bit 0 is channel A |
| opamp_on | output | 1 | Op-amp power-up |
| refbuf_sel | output | 2 | Reference-buffer setting |
| ref_en | output | 1 | Internal reference enable |

## Verification
The bench goes after the transfer mode. A design that wrote the incoming code instead of copying the held input register, or that overwrote the input register, would show a wrong output code or a wrong readback. It writes to channels in mode 00 and mode 10. A design that moved the output there would drive a code the host never committed. It writes the reference bit through the ADC location. A design with two separate copies of the bit, or one that clobbered the other control fields, would read back mismatched values. It also writes to unmapped addresses and to the other channel, to catch decode that leaks across channels.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

   localparam int NUM_CH = 2;
   localparam int CTRL_W = 8;

   typedef enum logic [1:0] {
      CHM_OFF      = 2'b00,
      CHM_XFER     = 2'b01,
      CHM_LOAD_IN  = 2'b10,
      CHM_LOAD_ALL = 2'b11
   } ch_mode_e;

   // bit position of the upper mode bit for channel ch in the control byte
   function automatic int mode_msb(input int ch);
      return CTRL_W - 1 - 2 * ch;
   endfunction

   localparam int OPAMP_BIT  = 3;
   localparam int REFBUF_MSB = 2;
   localparam int REF_BIT    = 0;

endpackage

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
   import dual_dac_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int BUS_W       = 16,
   parameter int CTRL_ADDR   = 2,
   parameter int ADC_ADDR    = 3,
   parameter int ADC_REF_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   output ch_mode_e          mode   [NUM_CH],
   output logic              opamp_q,
   output logic [1:0]        refbuf_q,
   output logic              ref_q,
   output logic [CTRL_W-1:0] ctrl_byte
);

   generate
      if (ADC_REF_BIT >= BUS_W) begin : g_bad_refbit
         $error("ADC_REF_BIT outside the bus");
      end
      if (CTRL_ADDR == ADC_ADDR) begin : g_bad_addr
         $error("control and ADC locations must differ");
      end
   endgenerate

   logic wr_ctrl, wr_adc;
   assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
   assign wr_adc  = wr_en && (wr_addr == ADDR_W'(ADC_ADDR));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
      localparam int HI = mode_msb(c);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mode[c] <= CHM_OFF;
         else if (wr_ctrl) mode[c] <= ch_mode_e'(wr_data[HI -: 2]);
      end
      assign ctrl_byte[HI -: 2] = mode[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opamp_q  <= 1'b0;
         refbuf_q <= 2'b00;
      end else if (wr_ctrl) begin
         opamp_q  <= wr_data[OPAMP_BIT];
         refbuf_q <= wr_data[REFBUF_MSB -: 2];
      end
   end

   // single stored reference bit, reachable from two locations
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ref_q <= 1'b0;
      else if (wr_ctrl) ref_q <= wr_data[REF_BIT];
      else if (wr_adc)  ref_q <= wr_data[ADC_REF_BIT];
   end

   assign ctrl_byte[OPAMP_BIT]        = opamp_q;
   assign ctrl_byte[REFBUF_MSB -: 2]  = refbuf_q;
   assign ctrl_byte[REF_BIT]          = ref_q;

   // R2: fields cleared while reset is held
   a_r2_ctrl_reset: assert property (@(posedge clk)
      !rst_n |-> (ctrl_byte == '0));

   // R8: an ADC-location write updates the shared bit and nothing else
   a_r8_adc_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_adc && !wr_ctrl) |=> (ref_q == $past(wr_data[ADC_REF_BIT]))
         && (ctrl_byte[CTRL_W-1:1] == $past(ctrl_byte[CTRL_W-1:1])));

   // R1: a control write stores the whole byte
   a_r1_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctrl_byte == $past(wr_data[CTRL_W-1:0])));

endmodule

// File: rtl/dual_dac_chan.sv
module dual_dac_chan
   import dual_dac_pkg::*;
#(
   parameter int DAC_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [DAC_W-1:0] wr_code,
   input  ch_mode_e         mode,
   output logic [DAC_W-1:0] in_code,
   output logic [DAC_W-1:0] out_code,
   output logic             powered,
   output logic             oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_code  <= '0;
         out_code <= '0;
      end else if (wr_stb) begin
         unique case (mode)
            CHM_OFF:      in_code  <= wr_code;
            CHM_XFER:     out_code <= in_code;
            CHM_LOAD_IN:  in_code  <= wr_code;
            CHM_LOAD_ALL: begin
               in_code  <= wr_code;
               out_code <= wr_code;
            end
            default: ;
         endcase
      end
   end

   assign powered = (mode != CHM_OFF);
   assign oe      = powered;

   a_r4_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && mode == CHM_XFER) |=>
         (out_code == $past(in_code)) && $stable(in_code));

   a_r5_load_in: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && mode == CHM_LOAD_IN) |=>
         $stable(out_code) && (in_code == $past(wr_code)));

   a_r6_load_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && mode == CHM_LOAD_ALL) |=>
         (out_code == $past(wr_code)) && (in_code == $past(wr_code)));

   a_r7_off_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && mode == CHM_OFF) |=>
         $stable(out_code) && (in_code == $past(wr_code)));

   a_r10_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(in_code) && $stable(out_code));

endmodule

// File: rtl/dual_dac_rdmux.sv
module dual_dac_rdmux
   import dual_dac_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int BUS_W       = 16,
   parameter int DAC_W       = 12,
   parameter int CH_BASE     = 0,
   parameter int CTRL_ADDR   = 2,
   parameter int ADC_ADDR    = 3,
   parameter int ADC_REF_BIT = 0
) (
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [NUM_CH*DAC_W-1:0] in_codes,
   input  logic [CTRL_W-1:0]       ctrl_byte,
   input  logic                    ref_q,
   output logic [BUS_W-1:0]        rd_data
);

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_addr == ADDR_W'(CH_BASE + c))
            rd_data[DAC_W-1:0] = in_codes[c*DAC_W +: DAC_W];
      end
      if (rd_addr == ADDR_W'(CTRL_ADDR))
         rd_data[CTRL_W-1:0] = ctrl_byte;
      if (rd_addr == ADDR_W'(ADC_ADDR))
         rd_data[ADC_REF_BIT] = ref_q;
   end

endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
   import dual_dac_pkg::*;
#(
   parameter int DAC_W       = 12,
   parameter int BUS_W       = 16,
   parameter int ADDR_W      = 3,
   parameter int CH_BASE     = 0,
   parameter int CTRL_ADDR   = 2,
   parameter int ADC_ADDR    = 3,
   parameter int ADC_REF_BIT = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [BUS_W-1:0]        wr_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [BUS_W-1:0]        rd_data,
   output logic [NUM_CH*DAC_W-1:0] ch_code,
   output logic [NUM_CH-1:0]       ch_powered,
   output logic [NUM_CH-1:0]       ch_oe,
   output logic                    opamp_on,
   output logic [1:0]              refbuf_sel,
   output logic                    ref_en
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (DAC_W > BUS_W || CTRL_W > BUS_W) begin : g_bad_bus
         $error("BUS_W narrower than a register");
      end
      if (CH_BASE + NUM_CH > ADDR_SPAN || CTRL_ADDR >= ADDR_SPAN
          || ADC_ADDR >= ADDR_SPAN) begin : g_bad_map
         $error("address map exceeds ADDR_W");
      end
      if ((CTRL_ADDR >= CH_BASE && CTRL_ADDR < CH_BASE + NUM_CH)
          || (ADC_ADDR >= CH_BASE && ADC_ADDR < CH_BASE + NUM_CH)) begin : g_overlap
         $error("control locations overlap channel data");
      end
   endgenerate

   ch_mode_e          mode [NUM_CH];
   logic [CTRL_W-1:0] ctrl_byte;
   logic              opamp_q, ref_q;
   logic [1:0]        refbuf_q;
   logic [NUM_CH*DAC_W-1:0] in_codes;

   dual_dac_ctrl #(
      .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CTRL_ADDR(CTRL_ADDR),
      .ADC_ADDR(ADC_ADDR), .ADC_REF_BIT(ADC_REF_BIT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .mode(mode), .opamp_q(opamp_q),
      .refbuf_q(refbuf_q), .ref_q(ref_q), .ctrl_byte(ctrl_byte)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic stb;
      assign stb = wr_en && (wr_addr == ADDR_W'(CH_BASE + c));

      dual_dac_chan #(.DAC_W(DAC_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .wr_stb(stb),
         .wr_code(wr_data[DAC_W-1:0]), .mode(mode[c]),
         .in_code(in_codes[c*DAC_W +: DAC_W]),
         .out_code(ch_code[c*DAC_W +: DAC_W]),
         .powered(ch_powered[c]), .oe(ch_oe[c])
      );

      // R3: a channel in mode 00 never enables its output
      a_r3_off_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_byte[mode_msb(c) -: 2] == 2'b00) |-> !ch_oe[c] && !ch_powered[c]);
   end

   dual_dac_rdmux #(
      .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DAC_W(DAC_W), .CH_BASE(CH_BASE),
      .CTRL_ADDR(CTRL_ADDR), .ADC_ADDR(ADC_ADDR), .ADC_REF_BIT(ADC_REF_BIT)
   ) u_rdmux (
      .rd_addr(rd_addr), .in_codes(in_codes), .ctrl_byte(ctrl_byte),
      .ref_q(ref_q), .rd_data(rd_data)
   );

   assign opamp_on   = opamp_q;
   assign refbuf_sel = refbuf_q;
   assign ref_en     = ref_q;

   // R9: the op-amp output follows control bit 3 after a control write
   a_r9_opamp: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=>
         (opamp_on == $past(wr_data[OPAMP_BIT])));

   // R11: an unmapped write leaves every output and the control byte alone
   a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(wr_addr == ADDR_W'(CTRL_ADDR)) && !(wr_addr == ADDR_W'(ADC_ADDR))
       && !(wr_addr >= ADDR_W'(CH_BASE) && wr_addr < ADDR_W'(CH_BASE + NUM_CH)))
      |=> $stable(ctrl_byte) && $stable(ch_code));

endmodule

// File: tb/dual_dac_regs_bench.sv
`timescale 1ns/1ps
module dual_dac_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [23:0] ch_code;
   logic [1:0]  ch_powered, ch_oe, refbuf_sel;
   logic        opamp_on, ref_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dual_dac_regs u_dual_dac_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ch_code(ch_code), .ch_powered(ch_powered), .ch_oe(ch_oe),
      .opamp_on(opamp_on), .refbuf_sel(refbuf_sel), .ref_en(ref_en)
   );

   // entry: addr, data, expected code A, expected code B, expected input A
   localparam int NV = 16;
   localparam logic [54:0] VEC [NV] = '{
      {3'd2, 16'h00E0, 12'h000, 12'h000, 12'h000}, // A=11 B=10
      {3'd0, 16'h0123, 12'h123, 12'h000, 12'h123}, // R6
      {3'd1, 16'h0456, 12'h123, 12'h000, 12'h123}, // R5 on B, R10
      {3'd2, 16'h00D0, 12'h123, 12'h000, 12'h123}, // A=11 B=01
      {3'd1, 16'h0FFF, 12'h123, 12'h456, 12'h123}, // R4 on B
      {3'd0, 16'h0ABC, 12'hABC, 12'h456, 12'hABC}, // R6
      {3'd2, 16'h0060, 12'hABC, 12'h456, 12'hABC}, // A=01 B=10
      {3'd0, 16'h0111, 12'hABC, 12'h456, 12'hABC}, // R4 data ignored
      {3'd2, 16'h00A0, 12'hABC, 12'h456, 12'hABC}, // A=10
      {3'd0, 16'h0222, 12'hABC, 12'h456, 12'h222}, // R5
      {3'd2, 16'h0060, 12'hABC, 12'h456, 12'h222}, // A=01
      {3'd0, 16'h0777, 12'h222, 12'h456, 12'h222}, // R4 transfer
      {3'd2, 16'h0000, 12'h222, 12'h456, 12'h222}, // both off
      {3'd0, 16'h0333, 12'h222, 12'h456, 12'h333}, // R7
      {3'd2, 16'h0040, 12'h222, 12'h456, 12'h333}, // A=01
      {3'd0, 16'h0000, 12'h333, 12'h456, 12'h333}  // R4 transfer after R7
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(100000 * 5);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2 reset state
      check("R2 codes", ch_code, 0);
      check("R2 powered", ch_powered, 0);
      check("R2 oe", ch_oe, 0);
      check("R2 opamp", opamp_on, 0);
      rd_addr = 3'd2; #0.1;
      check("R2 ctrl read", rd_data, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][54:52], VEC[i][51:36]);
         check("R4-R7 vector code A", ch_code[11:0], VEC[i][35:24]);
         check("R10 vector code B", ch_code[23:12], VEC[i][23:12]);
         rd_addr = 3'd0; #0.1;
         check("R10 vector input A readback", rd_data, {4'h0, VEC[i][11:0]});
      end
      rd_addr = 3'd1; #0.1;
      check("R10 input B readback", rd_data, 16'h0456);

      // R3 powered and oe per mode (A=01 B=00 now)
      check("R3 powered", ch_powered, 2'b01);
      check("R3 oe", ch_oe, 2'b01);
      wr(3'd2, 16'h0030); // A=00 B=11
      check("R3 powered swap", ch_powered, 2'b10);
      check("R3 oe swap", ch_oe, 2'b10);

      // R1 and R9 field layout
      wr(3'd2, 16'h00BD); // 10_11_1_10_1
      rd_addr = 3'd2; #0.1;
      check("R1 ctrl readback", rd_data, 16'h00BD);
      check("R9 opamp", opamp_on, 1);
      check("R9 refbuf", refbuf_sel, 2'b10);
      check("R9 ref", ref_en, 1);
      check("R3 both on", ch_powered, 2'b11);

      // R8 shared reference bit through the ADC location
      wr(3'd3, 16'hFFFE);
      check("R8 ref cleared", ref_en, 0);
      rd_addr = 3'd2; #0.1;
      check("R8 ctrl view", rd_data, 16'h00BC);
      rd_addr = 3'd3; #0.1;
      check("R8 adc view", rd_data, 16'h0000);
      wr(3'd3, 16'h0001);
      check("R8 ref set", ref_en, 1);
      rd_addr = 3'd3; #0.1;
      check("R8 adc readback", rd_data, 16'h0001);
      rd_addr = 3'd2; #0.1;
      check("R8 ctrl readback", rd_data, 16'h00BD);

      // R11 unmapped addresses
      wr(3'd5, 16'hFFFF);
      wr(3'd7, 16'h0000);
      rd_addr = 3'd2; #0.1;
      check("R11 ctrl untouched", rd_data, 16'h00BD);
      check("R11 codes untouched", ch_code, {12'h456, 12'h333});
      rd_addr = 3'd5; #0.1;
      check("R11 unmapped read", rd_data, 0);

      // R2 reset again clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R2 re-reset codes", ch_code, 0);
      check("R2 re-reset ref", ref_en, 0);
      rst_n = 1'b1;

      finish_run();
   end

endmodule